// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block carries out the "load several registers" and "store several registers" operations of a small processor core, both in the ascending, address-increments-after form. The core hands it the low twelve bits of the decoded operation together with the current value of the base register. The block walks the register list from register 0 upwards and issues one 32-bit access per selected register on a request/ready memory port. For a store, it takes each word from a register-file read port. For a load, it writes each returned word through a register-file write port. When the list is exhausted, it writes the advanced address back into the base register.

While the transfer runs, the block also adds up a cycle-cost figure for the operation. The figure is made of non-sequential, sequential and internal cycle weights, each a parameter, plus the waitstate count that the memory returns with every ready. The figure is available on `cost_out` when `done` is high and holds there until the next operation starts. The two directions start from different base costs, and a store trims one sequential cycle from its total.

Top module: `blkxfer_seq`

## Requirements
- R1: `op_word` is decoded as follows: bit 11 selects the direction (1 = load, 0 = store), bits 10:8 give the base register index, and bit i of bits 7:0 selects register i.
- R2: Selected registers are transferred one access each, in ascending index order, and unselected registers are never touched.
- R3: The first access uses `base_val`, and each completed word advances the address by 4. `mem_req` and `mem_addr` stay unchanged while `mem_ready` is low.
- R4: For a store, `mem_we` is 1 and `mem_wdata` equals the register named on `rf_rd_idx`, which is the register being transferred.
- R5: For a load, `mem_we` is 0, and in the cycle `mem_ready` is high the block writes `mem_rdata` to that register through `rf_we`/`rf_wr_idx`/`rf_wr_data`.
- R6: In the cycle `done` is high, the base register receives `base_val + 4*count`. For a load whose list holds the base, this writeback comes after the loaded value and so replaces it.
- R7: The cost of a store with at least one register is 2·N + Σ(S + wait) − S.
- R8: The cost of a load is N + I + Σ(S + wait).
- R9: An empty list makes no memory access. `done` rises in the cycle after start, and the unchanged base is written back with the base cost only (store 2·N, load N + I).
- R10: `busy` is high from the cycle after an accepted start through the `done` cycle, and low after that. A start while busy is ignored, and so are changes on `op_word`/`base_val` during that time.
- R11: While reset is held, `busy`, `done`, `mem_req`, `rf_we` and `cost_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op_word | input | 12 | Direction bit, base index, register list |
| base_val | input | 32 | Current base register value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final cycle: writeback and cost valid |
| cost_out | output | 16 | Accumulated cycle cost |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Load data, valid with ready |
| mem_wait | input | 4 | Waitstates of this access, valid with ready |
| rf_rd_idx | output | 3 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_idx | output | 3 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |

## Verification
The first request appears one cycle after the edge that samples `start`. Each later request follows the edge at which the previous `mem_ready` was taken. A load's register write appears in the same cycle as its ready. `done`, the base writeback and the final cost appear one cycle after the last ready, or one cycle after start for an empty list, and `busy` falls one cycle after that. The bench drives ready, data and waitstates at the falling edge, lets the combinational outputs settle, and checks each access, each register write, the writeback and the cost in exactly those cycles. Stall lengths vary from vector to vector, so the hold behaviour is checked too.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_WB   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/blkxfer_pick.sv
module blkxfer_pick #(
  parameter int NREG = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  req,
  output logic [NREG-1:0]  grant_oh,
  output logic [IDX_W-1:0] grant_idx
);
  logic [NREG-1:0] below;

  assign below[0] = 1'b0;
  for (genvar g = 0; g < NREG; g++) begin : g_chain
    if (g > 0) begin : g_or
      assign below[g] = below[g-1] | req[g-1];
    end
    assign grant_oh[g] = req[g] & ~below[g];
  end

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (grant_oh[i]) grant_idx = grant_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/blkxfer_cost.sv
module blkxfer_cost #(
  parameter int COST_W = 16,
  parameter int WAIT_W = 4,
  parameter int N_CYC  = 1,
  parameter int S_CYC  = 1,
  parameter int I_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_en,
  input  logic              init_load,
  input  logic              step_en,
  input  logic              step_load,
  input  logic              step_last,
  input  logic [WAIT_W-1:0] step_wait,
  output logic [COST_W-1:0] cost_q
);
  localparam logic [COST_W-1:0] BASE_LD = COST_W'(N_CYC + I_CYC);
  localparam logic [COST_W-1:0] BASE_ST = COST_W'(2 * N_CYC);
  localparam logic [COST_W-1:0] SEQ     = COST_W'(S_CYC);

  logic [COST_W-1:0] cost_d;
  logic              cost_en;

  always_comb begin
    cost_en = init_en | step_en;
    cost_d  = cost_q;
    if (init_en) begin
      cost_d = init_load ? BASE_LD : BASE_ST;
    end else if (step_en) begin
      cost_d = cost_q + SEQ + COST_W'(step_wait);
      if (!step_load && step_last) cost_d = cost_d - SEQ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cost_q <= '0;
    else if (cost_en) cost_q <= cost_d;
  end

  // R7 R8: a completed access never lowers the running cost
  a_r8_cost_nondec: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> cost_q >= $past(cost_q));
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  parameter int WAIT_W = 4,
  parameter int COST_W = 16,
  parameter int N_CYC  = 1,
  parameter int S_CYC  = 1,
  parameter int I_CYC  = 1,
  localparam int IDX_W = $clog2(NREG),
  localparam int OP_W  = NREG + IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   op_word,
  input  logic [ADDR_W-1:0] base_val,
  output logic              busy,
  output logic              done,
  output logic [COST_W-1:0] cost_out,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [WAIT_W-1:0] mem_wait,
  output logic [IDX_W-1:0]  rf_rd_idx,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_wr_idx,
  output logic [DATA_W-1:0] rf_wr_data
);
  import blkxfer_pkg::*;

  localparam int LOAD_BIT = NREG + IDX_W;
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  seq_state_t        state_q, state_d;
  logic [NREG-1:0]   list_q, list_d;
  logic              load_q, load_d;
  logic [IDX_W-1:0]  bidx_q, bidx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              reg_en;

  logic [NREG-1:0]   pick_oh;
  logic [IDX_W-1:0]  pick_idx;
  logic              accept, xfer_ack, last_xfer;
  logic [NREG-1:0]   list_rest;

  blkxfer_pick #(.NREG(NREG)) pick_i (
    .req       (list_q),
    .grant_oh  (pick_oh),
    .grant_idx (pick_idx)
  );

  assign accept    = (state_q == ST_IDLE) && start;
  assign xfer_ack  = (state_q == ST_XFER) && mem_ready;
  assign list_rest = list_q & ~pick_oh;
  assign last_xfer = (list_rest == '0);

  always_comb begin
    state_d = state_q;
    list_d  = list_q;
    load_d  = load_q;
    bidx_d  = bidx_q;
    addr_d  = addr_q;
    reg_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          reg_en  = 1'b1;
          load_d  = op_word[LOAD_BIT];
          bidx_d  = op_word[NREG +: IDX_W];
          list_d  = op_word[NREG-1:0];
          addr_d  = base_val;
          state_d = (op_word[NREG-1:0] != '0) ? ST_XFER : ST_WB;
        end
      end
      ST_XFER: begin
        if (mem_ready) begin
          reg_en = 1'b1;
          list_d = list_rest;
          addr_d = addr_q + WORD_STEP;
          if (last_xfer) state_d = ST_WB;
        end
      end
      ST_WB: begin
        reg_en  = 1'b1;
        state_d = ST_IDLE;
      end
      default: begin
        reg_en  = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      list_q  <= '0;
      load_q  <= 1'b0;
      bidx_q  <= '0;
      addr_q  <= '0;
    end else if (reg_en) begin
      state_q <= state_d;
      list_q  <= list_d;
      load_q  <= load_d;
      bidx_q  <= bidx_d;
      addr_q  <= addr_d;
    end
  end

  blkxfer_cost #(
    .COST_W(COST_W), .WAIT_W(WAIT_W),
    .N_CYC(N_CYC), .S_CYC(S_CYC), .I_CYC(I_CYC)
  ) cost_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_en   (accept),
    .init_load (op_word[LOAD_BIT]),
    .step_en   (xfer_ack),
    .step_load (load_q),
    .step_last (last_xfer),
    .step_wait (mem_wait),
    .cost_q    (cost_out)
  );

  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_WB);
  assign mem_req    = (state_q == ST_XFER);
  assign mem_we     = mem_req & ~load_q;
  assign mem_addr   = addr_q;
  assign rf_rd_idx  = pick_idx;
  assign mem_wdata  = rf_rd_data;
  assign rf_we      = (xfer_ack & load_q) | done;
  assign rf_wr_idx  = done ? bidx_q : pick_idx;
  assign rf_wr_data = done ? DATA_W'(addr_q) : mem_rdata;

  // R3: a stalled request holds its address
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
  // R3: the next request is one word further on
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=> (!mem_req || mem_addr == $past(mem_addr) + WORD_STEP));
  // R2: at most one register is selected per access
  a_r2_one_reg: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $onehot0(pick_oh) && (pick_oh != '0));
  // R10: busy falls right after done, and done lasts one cycle
  a_r10_done_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));
  // R10: busy persists until done
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: tb/blkxfer_seq_tb_top.sv
module blkxfer_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 3, SC = 1, IC = 2;
  localparam int NVEC = 6;
  // {load, base idx, list, base value, stall}
  localparam logic [47:0] VEC [NVEC] = '{
    {1'b0, 3'd1, 8'hA5, 32'h0000_2000, 4'd0},
    {1'b1, 3'd2, 8'h3C, 32'h0000_3100, 4'd1},
    {1'b0, 3'd0, 8'hFF, 32'h0000_4000, 4'd0},
    {1'b1, 3'd7, 8'h81, 32'h0000_5004, 4'd2},
    {1'b1, 3'd3, 8'h08, 32'h0000_6000, 4'd0},
    {1'b0, 3'd5, 8'h80, 32'h0000_7FFC, 4'd1}
  };

  logic        clk, rst_n, start;
  logic [11:0] op_word;
  logic [31:0] base_val;
  logic        busy, done, mem_req, mem_we, mem_ready, rf_we;
  logic [15:0] cost_out;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wr_data;
  logic [3:0]  mem_wait;
  logic [2:0]  rf_rd_idx, rf_wr_idx;
  logic [31:0] rf [8];
  int errors = 0, checks = 0;

  assign rf_rd_data = rf[rf_rd_idx];

  blkxfer_seq #(.N_CYC(NC), .S_CYC(SC), .I_CYC(IC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_word(op_word),
    .base_val(base_val), .busy(busy), .done(done), .cost_out(cost_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .mem_wait(mem_wait), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic ld, input logic [2:0] b, input logic [7:0] lst,
                        input logic [31:0] bv, input int stall, input logic poke);
    logic [7:0]  rem = lst;
    int          n = 0, stallc = 0, guard = 0, exp_cost;
    logic [31:0] ea;
    int          idx;
    logic [3:0]  w;
    logic        acc_ok = 1'b1, wr_ok = 1'b1, hold_ok = 1'b1;
    exp_cost = ld ? (NC + IC) : (2 * NC);
    rf[b] = bv;
    op_word = {ld, b, lst};
    base_val = bv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 200) begin
      mem_ready = 1'b0;
      if (poke && guard == 0) begin
        start = 1'b1; op_word = 12'h4FF; base_val = 32'hDEAD_0000;
      end else begin
        start = 1'b0;
      end
      ea = bv + 32'(4 * n);
      if (mem_req) begin
        idx = 0;
        for (int i = 7; i >= 0; i--) if (rem[i]) idx = i;
        if (stallc < stall) begin
          stallc++;
          #1;
          if (mem_addr != ea) hold_ok = 1'b0;
        end else begin
          stallc = 0;
          w = 4'(((ea >> 2) + 32'(b)) & 32'h3);
          mem_ready = 1'b1; mem_wait = w; mem_rdata = ea ^ 32'hA5A5_0000;
          #1;
          if (mem_addr != ea || mem_we != !ld) acc_ok = 1'b0;
          if (!ld && (rf_rd_idx != 3'(idx) || mem_wdata != rf[idx])) acc_ok = 1'b0;
          if (ld) begin
            if (!rf_we || rf_wr_idx != 3'(idx) || rf_wr_data != mem_rdata) wr_ok = 1'b0;
            rf[idx] = mem_rdata;
          end else if (rf_we) wr_ok = 1'b0;
          exp_cost += SC + int'(w);
          rem[idx] = 1'b0;
          n++;
        end
      end
      @(negedge clk);
      guard++;
    end
    mem_ready = 1'b0; start = 1'b0;
    if (!ld && n > 0) exp_cost -= SC;
    check(done, "R10 done reached", 32'(done), 32'd1);
    check(acc_ok, "R2/R3 R4 access order, address, data", 32'(n), 32'($countones(lst)));
    check(hold_ok, "R3 address held in stall", mem_addr, ea);
    check(wr_ok, "R5 load register writes", 32'(rf_wr_idx), 32'(idx));
    check(rem == 8'h00 && n == $countones(lst), "R2 access count", 32'(n),
          32'($countones(lst)));
    check(rf_we && rf_wr_idx == b, "R1 R6 writeback index", 32'(rf_wr_idx), 32'(b));
    check(rf_wr_data == bv + 32'(4 * n), "R6 writeback value", rf_wr_data,
          bv + 32'(4 * n));
    check(cost_out == 16'(exp_cost), ld ? "R8 load cost" : "R7 store cost",
          32'(cost_out), 32'(exp_cost));
    if (rf_we) rf[rf_wr_idx] = rf_wr_data;
    @(negedge clk);
    check(!busy && !done, "R10 idle after done", 32'(busy), 32'd0);
    check(rf[b] == bv + 32'(4 * n), "R6 base holds writeback", rf[b], bv + 32'(4 * n));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_word = '0; base_val = '0;
    mem_ready = 1'b0; mem_rdata = '0; mem_wait = '0;
    for (int i = 0; i < 8; i++) rf[i] = 32'h1000_0000 + 32'(i * 32'h111);
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req && !rf_we && cost_out == 0, "R11 reset state",
          {busy, done, mem_req, rf_we, 12'h0, cost_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NVEC; v++) begin
      run_op(VEC[v][47], VEC[v][46:44], VEC[v][43:36], VEC[v][35:4], int'(VEC[v][3:0]),
             1'b0);
    end
    // R9: empty lists, both directions
    run_op(1'b0, 3'd4, 8'h00, 32'h0000_8000, 0, 1'b0);
    run_op(1'b1, 3'd6, 8'h00, 32'h0000_9000, 0, 1'b0);
    // R10: start and new operands while busy are ignored
    run_op(1'b0, 3'd2, 8'h52, 32'h0000_A000, 1, 1'b1);
    run_op(1'b1, 3'd0, 8'h0F, 32'h0000_B000, 0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule